// File: doc/BRIEF.md
# Multistep Iterative Restoration Mesh

This block restores a small image tile by running a fixed-point iteration on a grid of pixel elements, one element per pixel. Every element stores an offset value and a short history of its own past restored values. Every step uses only the values of the element and its eight adjacent elements. The large restoration filter is split into several 3x3 component kernels. Component l, counting from 1, is applied to the iterate from l steps back. The new value is the sum of these terms plus the offset. Because of this split, no element ever needs data from more than one position away.

Software first writes the offset image and the component weights through a single load port. It then gives a start strobe together with an iteration count. When the last step has been committed, the done flag rises, and the restored tile comes out in raster order, one pixel per cycle. Pixels are 16-bit signed values. Weights are 16-bit signed values with 14 fractional bits.

Top module: `restore_mesh`

## Requirements
- R1: After reset, done and out_valid are low, and all offsets and weights read as zero.
- R2: With an iteration count of zero, the streamed tile equals the loaded offset image.
- R3: One step computes, for each pixel, the offset plus the sum over taps of weight times neighbour value. Tap t=(dr+1)*3+(dc+1) weights the pixel at row offset dr and column offset dc, with both offsets in -1..1. Component k's tap t is loaded with ld_sel=1 at address k*9+t. Pixel p=row*8+col is loaded with ld_sel=0 at address p.
- R4: Component k (0-based) multiplies the iterate from k+1 steps back. Before the first step, every history entry equals the offset image.
- R5: A neighbour position outside the tile contributes zero.
- R6: The full-width sum is rounded by adding 2^13 and then shifting right arithmetically by 14. The result is saturated to the range -32768..32767.
- R7: Count the edge that samples start as edge 1. done rises on edge 5*N+2, where N is the iteration count.
- R8: out_valid is low in the cycle where done first shows high. It is then high for exactly 64 consecutive cycles and carries pixels 0 to 63 in raster order.
- R9: While a run or a readout is in progress, a start strobe and any load write are ignored.
- R10: done stays high after the readout and drops on the edge that accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load write strobe |
| ld_sel | input | 1 | 0 selects an offset pixel, 1 selects a weight |
| ld_addr | input | 6 | Pixel index or weight index |
| ld_data | input | 16 | Value to write |
| start | input | 1 | Starts a run |
| iters | input | 8 | Number of iteration steps |
| done | output | 1 | Run finished; result available |
| out_valid | output | 1 | out_pix carries a pixel of the readout |
| out_pix | output | 16 | Restored pixel, signed |

## Verification
A history shift that is off by one position, or a component applied at the wrong depth, leaves the first step correct. The fault becomes visible in the second step at the earliest and changes nearly every pixel of the tile. This is why the multistep cases run at least six steps with all four components active. A fault in the edge handling shows only in row 0, row 7, column 0 and column 7, and it appears as soon as the first readout after one step. A sequencing fault moves the cycle in which done rises, so the bench checks that cycle exactly for several iteration counts.

// File: rtl/restore_pkg.sv
package restore_pkg;
    localparam int PIX_W  = 16;
    localparam int FRAC_W = 14;
    localparam int ACC_W  = 40;
    localparam int TAPS   = 9;
    localparam longint PIX_MAX = (64'sd1 <<< (PIX_W - 1)) - 1;
    localparam longint PIX_MIN = -(64'sd1 <<< (PIX_W - 1));

    typedef logic signed [PIX_W-1:0] pix_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INIT, ST_XCHG, ST_ACC, ST_READ, ST_DONE
    } state_e;

    typedef struct packed {
        logic init;
        logic xchg;
        logic acc;
        logic commit;
    } pe_ctl_t;

    function automatic pix_t round_sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] half;
        logic signed [ACC_W-1:0] r;
        half = '0;
        half[FRAC_W-1] = 1'b1;
        r = (a + half) >>> FRAC_W;
        if (r > ACC_W'(PIX_MAX))      return pix_t'(PIX_MAX);
        else if (r < ACC_W'(PIX_MIN)) return pix_t'(PIX_MIN);
        else                          return pix_t'(r);
    endfunction
endpackage

// File: rtl/restore_ctrl.sv
module restore_ctrl
    import restore_pkg::*;
#(
    parameter int NK   = 4,
    parameter int NPIX = 64,
    parameter int CW   = 8,
    localparam int PHW = (NK > 1) ? $clog2(NK) : 1,
    localparam int RIW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CW-1:0]  iters,
    output logic           busy,
    output pe_ctl_t        ctl,
    output logic [PHW-1:0] phase,
    output logic           rd_go,
    output logic [RIW-1:0] rd_idx,
    output logic           done
);
    state_e         state;
    logic [CW-1:0]  left;
    logic [PHW-1:0] ph_q;
    logic [RIW-1:0] rd_q;
    logic           done_q;
    logic           accept;

    assign accept = start && (state == ST_IDLE || state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            left   <= '0;
            ph_q   <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        state  <= ST_INIT;
                        left   <= iters;
                        done_q <= 1'b0;
                    end
                end
                ST_INIT: begin
                    if (left == '0) begin
                        state  <= ST_READ;
                        rd_q   <= '0;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_XCHG;
                    end
                end
                ST_XCHG: begin
                    state <= ST_ACC;
                    ph_q  <= '0;
                end
                ST_ACC: begin
                    if (ph_q == PHW'(NK - 1)) begin
                        left <= left - 1'b1;
                        if (left == CW'(1)) begin
                            state  <= ST_READ;
                            rd_q   <= '0;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_XCHG;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_READ: begin
                    rd_q <= rd_q + 1'b1;
                    if (rd_q == RIW'(NPIX - 1)) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = !(state == ST_IDLE || state == ST_DONE);
    assign ctl.init   = (state == ST_INIT);
    assign ctl.xchg   = (state == ST_XCHG);
    assign ctl.acc    = (state == ST_ACC);
    assign ctl.commit = (state == ST_ACC) && (ph_q == PHW'(NK - 1));
    assign phase      = ph_q;
    assign rd_go      = (state == ST_READ);
    assign rd_idx     = rd_q;
    assign done       = done_q;

    // R10: an accepted start clears done on the next edge
    p_done_clear_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);
    // R9: a start that arrives during a run leaves the sequence where it was
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (start && busy && state != ST_READ) |=> state != ST_INIT);
    // R7: done rises only on entry to the readout
    p_done_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> state == ST_READ);
endmodule

// File: rtl/restore_wbank.sv
module restore_wbank
    import restore_pkg::*;
#(
    parameter int NK = 4,
    parameter int AW = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  pix_t                          data,
    output pix_t [NK-1:0][TAPS-1:0]       wts
);
    pix_t [NK-1:0][TAPS-1:0] w_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '0;
        end else if (we) begin
            for (int k = 0; k < NK; k++)
                for (int t = 0; t < TAPS; t++)
                    if (addr == AW'(k * TAPS + t)) w_q[k][t] <= data;
        end
    end

    assign wts = w_q;
endmodule

// File: rtl/restore_pe.sv
module restore_pe
    import restore_pkg::*;
#(
    parameter int NK   = 4,
    localparam int PHW = (NK > 1) ? $clog2(NK) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ld_we,
    input  pix_t                          ld_val,
    input  pe_ctl_t                       ctl,
    input  logic [PHW-1:0]                phase,
    input  pix_t [TAPS-1:0][NK-1:0]       nb_in,
    input  pix_t [NK-1:0][TAPS-1:0]       wts,
    output pix_t [NK-1:0]                 hist
);
    pix_t                     b_q;
    pix_t [NK-1:0]            hist_q;
    pix_t [TAPS-1:0][NK-1:0]  nb_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  part;
    logic signed [ACC_W-1:0]  sum_all;

    always_comb begin
        part = '0;
        for (int t = 0; t < TAPS; t++)
            part = part + ACC_W'($signed(wts[phase][t])) * ACC_W'($signed(nb_q[t][phase]));
    end
    assign sum_all = acc_q + part;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q    <= '0;
            hist_q <= '0;
            nb_q   <= '0;
            acc_q  <= '0;
        end else begin
            if (ld_we) b_q <= ld_val;
            if (ctl.init) begin
                for (int k = 0; k < NK; k++) hist_q[k] <= b_q;
            end
            if (ctl.xchg) begin
                nb_q  <= nb_in;
                acc_q <= ACC_W'($signed(b_q)) <<< FRAC_W;
            end
            if (ctl.acc) acc_q <= sum_all;
            if (ctl.commit) begin
                hist_q[0] <= round_sat(sum_all);
                for (int k = 1; k < NK; k++) hist_q[k] <= hist_q[k-1];
            end
        end
    end

    assign hist = hist_q;

    // R9: the offset changes only through an accepted load write
    p_offset_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ld_we |=> $stable(b_q));
    // R4: the history moves only on init or commit
    p_hist_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(ctl.init || ctl.commit) |=> $stable(hist_q));
    // R4: after a commit, the previous newest value sits one place deeper
    p_hist_shift_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.commit |=> hist_q[1] == $past(hist_q[0]));
endmodule

// File: rtl/restore_mesh.sv
module restore_mesh
    import restore_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int NK   = 4,
    parameter int CW   = 8,
    localparam int NPIX = ROWS * COLS,
    localparam int NWGT = NK * TAPS,
    localparam int AW   = $clog2((NPIX > NWGT) ? NPIX : NWGT),
    localparam int PHW  = (NK > 1) ? $clog2(NK) : 1,
    localparam int RIW  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [AW-1:0]    ld_addr,
    input  logic [PIX_W-1:0] ld_data,
    input  logic             start,
    input  logic [CW-1:0]    iters,
    output logic             done,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    logic                    busy;
    pe_ctl_t                 ctl;
    logic [PHW-1:0]          phase;
    logic                    rd_go;
    logic [RIW-1:0]          rd_idx;
    logic                    ld_ok;
    pix_t [NK-1:0][TAPS-1:0] wts;
    pix_t [NK-1:0]           hist_all [NPIX];
    logic                    ov_q;
    pix_t                    op_q;

    assign ld_ok = ld_en && !busy;

    restore_ctrl #(.NK(NK), .NPIX(NPIX), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .iters(iters), .busy(busy),
        .ctl(ctl), .phase(phase), .rd_go(rd_go), .rd_idx(rd_idx), .done(done)
    );

    restore_wbank #(.NK(NK), .AW(AW)) u_wbank (
        .clk(clk), .rst(rst), .we(ld_ok && ld_sel), .addr(ld_addr),
        .data(pix_t'(ld_data)), .wts(wts)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            pix_t [TAPS-1:0][NK-1:0] nb;
            for (genvar dr = 0; dr < 3; dr++) begin : g_dr
                for (genvar dc = 0; dc < 3; dc++) begin : g_dc
                    localparam int RR = r + dr - 1;
                    localparam int CC = c + dc - 1;
                    if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
                        assign nb[dr*3+dc] = hist_all[RR*COLS+CC];
                    end else begin : g_out
                        assign nb[dr*3+dc] = '0;
                    end
                end
            end
            restore_pe #(.NK(NK)) u_pe (
                .clk(clk), .rst(rst),
                .ld_we(ld_ok && !ld_sel && ld_addr == AW'(IDX)),
                .ld_val(pix_t'(ld_data)), .ctl(ctl), .phase(phase),
                .nb_in(nb), .wts(wts), .hist(hist_all[IDX])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q <= 1'b0;
            op_q <= '0;
        end else begin
            ov_q <= rd_go;
            op_q <= hist_all[rd_idx][0];
        end
    end

    assign out_valid = ov_q;
    assign out_pix   = op_q;

    // R8: readout happens only while done is up
    p_valid_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> done);
    // R8: out_valid is low in the cycle where done first shows high
    p_valid_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !out_valid);
endmodule

// File: tb/restore_mesh_test.sv
module restore_mesh_test;
    localparam int CLK_P = 10;
    localparam int NP = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en, ld_sel, start;
    logic [5:0]  ld_addr;
    logic [15:0] ld_data;
    logic [7:0]  iters;
    logic        done, out_valid;
    logic [15:0] out_pix;

    int checks = 0;
    int errors = 0;
    int seed = 12345;
    int m_b [NP];
    int m_w [4][9];
    int expv [NP];

    always #(CLK_P/2) clk = ~clk;

    restore_mesh uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_data(ld_data), .start(start), .iters(iters), .done(done),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 1103515245 + 12345;
        return lo + int'((seed >>> 8) & 32'h7fffff) % (hi - lo + 1);
    endfunction

    task automatic ld(input bit sel, input int addr, input int val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = 6'(addr); ld_data = 16'(val);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all();
        for (int p = 0; p < NP; p++) ld(1'b0, p, m_b[p]);
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 9; t++) ld(1'b1, k * 9 + t, m_w[k][t]);
    endtask

    function automatic void clear_w();
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 9; t++) m_w[k][t] = 0;
    endfunction

    function automatic void model(input int n);
        longint h [4][NP];
        longint nv [NP];
        for (int k = 0; k < 4; k++)
            for (int p = 0; p < NP; p++) h[k][p] = m_b[p];
        for (int s = 0; s < n; s++) begin
            for (int p = 0; p < NP; p++) begin
                longint acc;
                acc = longint'(m_b[p]) <<< 14;
                for (int l = 0; l < 4; l++)
                    for (int t = 0; t < 9; t++) begin
                        int rr, cc;
                        rr = p / 8 + t / 3 - 1;
                        cc = p % 8 + t % 3 - 1;
                        if (rr >= 0 && rr < 8 && cc >= 0 && cc < 8)
                            acc += longint'(m_w[l][t]) * h[l][rr * 8 + cc];
                    end
                acc = (acc + 8192) >>> 14;
                if (acc > 32767) acc = 32767;
                if (acc < -32768) acc = -32768;
                nv[p] = acc;
            end
            for (int p = 0; p < NP; p++) begin
                h[3][p] = h[2][p]; h[2][p] = h[1][p]; h[1][p] = h[0][p]; h[0][p] = nv[p];
            end
        end
        for (int p = 0; p < NP; p++) expv[p] = int'(h[0][p]);
    endfunction

    // runs n steps, checks done timing (R7, R10), readout (R8) and pixels
    task automatic run(input int n, input string req, input bit disturb);
        int cnt;
        model(n);
        @(negedge clk);
        start = 1'b1; iters = 8'(n);
        cnt = 0;
        forever begin
            @(negedge clk);
            start = 1'b0; ld_en = 1'b0;
            cnt++;
            if (cnt == 1) chk(done == 1'b0, "R10 done clears on start", int'(done), 0);
            if (disturb && cnt == 3) begin
                start = 1'b1; iters = 8'd1;
                ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 6'd0; ld_data = 16'd12345;
            end
            if (disturb && cnt == 4) begin
                ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 6'd4; ld_data = 16'd9999;
            end
            if (done || cnt > 2000) break;
        end
        chk(cnt == 5 * n + 2, "R7 done edge", cnt, 5 * n + 2);
        chk(out_valid == 1'b0, "R8 valid low with first done", int'(out_valid), 0);
        for (int i = 0; i < NP; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R8 valid run", int'(out_valid), 1);
            chk($signed(out_pix) == expv[i], req, int'($signed(out_pix)), expv[i]);
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 valid ends after 64", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        for (int p = 0; p < NP; p++) m_b[p] = 0;
        clear_w();
        run(1, "R1 zero state", 1'b0);
    endtask

    task automatic t_identity();
        for (int p = 0; p < NP; p++) m_b[p] = rnd(-20000, 20000);
        clear_w();
        m_w[0][4] = 16384;
        load_all();
        run(0, "R2 zero iterations", 1'b0);
    endtask

    task automatic t_single();
        clear_w();
        m_w[0][4] = 8192; m_w[0][1] = 4096; m_w[0][5] = -2048;
        load_all();
        run(3, "R3 single component", 1'b0);
    endtask

    task automatic t_boundary();
        for (int p = 0; p < NP; p++) m_b[p] = 1000 + p;
        clear_w();
        m_w[0][0] = 16384; m_w[0][8] = 16384;
        load_all();
        run(1, "R5 edge zero", 1'b0);
        // pixel 0: up-left is off tile, down-right (9) contributes 1009
        chk(expv[0] == 1000 + 1009, "R5 corner model", expv[0], 2009);
    endtask

    task automatic t_multi();
        for (int p = 0; p < NP; p++) m_b[p] = rnd(-3000, 3000);
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 9; t++) m_w[k][t] = rnd(-1500, 1500);
        load_all();
        run(6, "R4 multistep", 1'b0);
        clear_w();
        m_w[3][4] = 16384;
        load_all();
        run(7, "R4 deepest component", 1'b0);
    endtask

    task automatic t_round_sat();
        for (int p = 0; p < NP; p++) m_b[p] = (p < 32) ? 30000 : -30000;
        m_b[40] = 1; m_b[41] = -1;
        clear_w();
        m_w[0][4] = 8192;
        m_w[1][4] = 24000;
        load_all();
        run(2, "R6 round and saturate", 1'b0);
        chk(expv[0] == 32767, "R6 top clamp", expv[0], 32767);
        chk(expv[63] == -32768, "R6 bottom clamp", expv[63], -32768);
        clear_w();
        m_w[0][4] = 8192;
        load_all();
        run(1, "R6 half-up rounding", 1'b0);
        chk(expv[40] == 2 && expv[41] == -1, "R6 half values", expv[40], 2);
    endtask

    task automatic t_busy();
        for (int p = 0; p < NP; p++) m_b[p] = rnd(-5000, 5000);
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 9; t++) m_w[k][t] = rnd(-2000, 2000);
        load_all();
        run(4, "R9 disturbed run", 1'b1);
        run(2, "R9 state kept after disturb", 1'b0);
    endtask

    task automatic t_hold();
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R10 done holds", int'(done), 1);
        chk(out_valid == 1'b0, "R10 no extra readout", int'(out_valid), 0);
        run(0, "R10 restart", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
        start = 1'b0; iters = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_identity();
        t_single();
        t_boundary();
        t_multi();
        t_round_sat();
        t_busy();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule